// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers interrupt requests from nine peripheral sources. It sorts them into eight level slots and hands the CPU one vector at a time. Each source has its own pending flag, which latches a request whether or not that request can be forwarded at the moment. Arbitration runs in two tiers. The first tier chooses a level, using ranks that software loads into a priority register, so a level's number says nothing about its urgency. The second tier works inside the chosen level and takes the source with the lowest index, an order fixed in hardware.

The CPU sees a registered request line and a vector number, and it answers with a one-cycle acknowledge. On that acknowledge, a source marked for automatic clearing loses its pending flag. A source marked for software clearing keeps its flag until software writes a 1 to the matching clear bit. Level 5 has no source, so it never raises a request. Configuration goes through a small write port that holds the rank register, the level enables and the clear strobes.

Top module: `irq_two_tier_ctrl`

## Requirements
- R1: While reset is held low and on the cycle after it, `irq` is 0 and `vec` is 0, and no pending flag is set.
- R2: A request pulse on `src_req[i]` sets pending flag i on the next clock edge even when its level is disabled or `glb_en` is low. Once the level is enabled and `glb_en` is high, `irq` rises one edge after the enabling condition is seen.
- R3: The vector presented for source i is `VEC_BASE + 2*i`, with `VEC_BASE` defaulting to 0x20.
- R4: The rank register (address 0) holds three rank fields. Bits [2:0] rank levels 0–2, bits [5:3] rank levels 3–4, and bits [7:6], zero-extended, rank levels 6–7. The eligible level with the numerically smallest rank wins.
- R5: When two eligible levels have equal rank, the level with the lower number wins.
- R6: Within a level the lower source index wins: source 0 before source 1 (level 0), and source 3 before source 4 (level 2).
- R7: With `glb_en` low, `irq` is 0 on the following cycle, including when a request was being presented.
- R8: An acknowledge while `irq` is high drops `irq` for one cycle. For an automatic-clear source (default sources 0, 2, 5, 6, 8) it also clears that pending flag, after which the next eligible source is presented.
- R9: For a software-clear source (default sources 1, 3, 4, 7) an acknowledge leaves the flag set, so the same vector is presented again after the one-cycle gap.
- R10: Writing 1 to a bit at address 2 (sources 0–7) clears that pending flag. Bits written 0 have no effect. If the presented source is cleared, `irq` drops one cycle after the write edge.
- R11: While `irq` is high and no acknowledge is given, `vec` does not change, even if a higher-priority request becomes pending.
- R12: Address 1 is a per-level enable (bit n enables level n, reset 0). At address 3, bit 0 clears the pending flag of source 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 9 | Per-source request, sampled each edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 rank, 1 level enable, 2/3 pending clear) |
| cfg_wdata | input | 8 | Configuration write data |
| glb_en | input | 1 | Global interrupt enable |
| ack | input | 1 | CPU acknowledge, one cycle |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Vector of the presented source |

## Verification
The bench loads rank patterns in which level numbers and ranks disagree. A design that ignores the register, or that decodes a field from the wrong bits, then presents the vectors in level-number order. It raises equal-rank collisions both inside one rank group and across groups, which exposes a tie-break that prefers the higher level. It also contrasts automatic and software clearing on acknowledge: a controller that clears every source would never re-present a software-clear vector, and one that clears none would present the same vector forever. Last, a higher-priority source arrives while a vector is on display. A controller without the hold would swap `vec` under an active request.

// File: rtl/irq_tt_pkg.sv
// Package: shared sizes, types and the fixed source-to-level map for the
// two-tier interrupt controller. Assumes nine sources and eight level slots.
package irq_tt_pkg;
    localparam int NUM_SRC = 9;
    localparam int NUM_LVL = 8;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int RANK_W  = 3;
    localparam int CFG_W   = 8;

    typedef logic [SRC_W-1:0]  src_idx_t;
    typedef logic [LVL_W-1:0]  lvl_idx_t;
    typedef logic [RANK_W-1:0] rank_t;

    typedef enum logic [1:0] {
        CFG_RANK   = 2'd0,
        CFG_LVL_EN = 2'd1,
        CFG_CLR_LO = 2'd2,
        CFG_CLR_HI = 2'd3
    } cfg_addr_e;

    // Fixed wiring of sources onto levels; level 5 carries no source.
    function automatic lvl_idx_t src_level(input int s);
        case (s)
            0, 1:    return 3'd0;
            2:       return 3'd1;
            3, 4:    return 3'd2;
            5:       return 3'd3;
            6:       return 3'd4;
            7:       return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    // Rank of a level taken from the rank register fields.
    function automatic rank_t level_rank(input int l, input logic [CFG_W-1:0] rr);
        if (l < 3)      return rr[2:0];
        else if (l < 5) return rr[5:3];
        else            return {1'b0, rr[7:6]};
    endfunction
endpackage

// File: rtl/irq_tt_cfg.sv
// Configuration registers: level rank register, per-level enable and the
// one-cycle software clear strobes for the pending flags.
// Assumes a single write port; strobes are combinational from the write.
module irq_tt_cfg
    import irq_tt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   rank_reg,
    output logic [NUM_LVL-1:0] lvl_en,
    output logic [NUM_SRC-1:0] clr_sw
);
    localparam int CLR_W = 2 * CFG_W;

    logic [CLR_W-1:0] clr_wide;
    logic             unused_clr_hi;

    // Store rank and level-enable registers on writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_reg <= '0;
            lvl_en   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_RANK)   rank_reg <= cfg_wdata;
            if (cfg_addr == CFG_LVL_EN) lvl_en   <= cfg_wdata[NUM_LVL-1:0];
        end
    end

    // Build the write-one-to-clear strobe across both clear addresses.
    always_comb begin
        clr_wide = '0;
        if (cfg_we && cfg_addr == CFG_CLR_LO) clr_wide[CFG_W-1:0]     = cfg_wdata;
        if (cfg_we && cfg_addr == CFG_CLR_HI) clr_wide[CLR_W-1:CFG_W] = cfg_wdata;
        clr_sw = clr_wide[NUM_SRC-1:0];
    end

    assign unused_clr_hi = ^clr_wide[CLR_W-1:NUM_SRC];
endmodule

// File: rtl/irq_tt_pend.sv
// Pending flags, one per source. A request sets the flag; a software or
// acknowledge clear resets it; a request in the same cycle wins over a clear.
module irq_tt_pend
    import irq_tt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr_sw,
    input  logic [NUM_SRC-1:0] clr_ack,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        // Set on request, clear on either clear strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)                      pend[i] <= 1'b0;
            else if (req[i])                 pend[i] <= 1'b1;
            else if (clr_sw[i] || clr_ack[i]) pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_tt_arb.sv
// Two-tier arbiter, purely combinational. Tier one takes the enabled level
// with a pending source and the smallest rank, lower level number on a tie.
// Tier two takes the lowest-index pending source inside that level.
module irq_tt_arb
    import irq_tt_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_LVL-1:0] lvl_en,
    input  logic [CFG_W-1:0]   rank_reg,
    output logic               any_req,
    output src_idx_t           win_src
);
    logic [NUM_LVL-1:0] lvl_hit;
    logic [NUM_LVL-1:0] lvl_req;
    lvl_idx_t           best_lvl;
    rank_t              best_rank;

    // Collect pending sources onto their levels and mask disabled levels.
    always_comb begin
        lvl_hit = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pend[s]) lvl_hit[src_level(s)] = 1'b1;
        end
        lvl_req = lvl_hit & lvl_en;
    end

    // Level tier: strict less-than keeps the lower level on equal rank.
    always_comb begin
        any_req   = 1'b0;
        best_lvl  = '0;
        best_rank = '1;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_req[l] && (!any_req || level_rank(l, rank_reg) < best_rank)) begin
                any_req   = 1'b1;
                best_lvl  = LVL_W'(l);
                best_rank = level_rank(l, rank_reg);
            end
        end
    end

    // Source tier: scan downward so the lowest matching index remains.
    always_comb begin
        win_src = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend[s] && src_level(s) == best_lvl) win_src = SRC_W'(s);
        end
    end
endmodule

// File: rtl/irq_two_tier_ctrl.sv
// Top of the two-tier interrupt controller. Registers the request and the
// vector and holds the vector while the request is high. On acknowledge it
// drops the request for one cycle and clears auto-clear sources.
// Assumes ack is asserted only for one cycle per serviced request.
module irq_two_tier_ctrl
    import irq_tt_pkg::*;
#(
    parameter int                 VEC_W    = 8,
    parameter logic [VEC_W-1:0]   VEC_BASE = 8'h20,
    parameter logic [NUM_SRC-1:0] AUTO_CLR = 9'h165
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               glb_en,
    input  logic               ack,
    output logic               irq,
    output logic [VEC_W-1:0]   vec
);
    logic [CFG_W-1:0]   rank_reg;
    logic [NUM_LVL-1:0] lvl_en;
    logic [NUM_SRC-1:0] clr_sw;
    logic [NUM_SRC-1:0] clr_ack;
    logic [NUM_SRC-1:0] pend;
    logic               any_req;
    src_idx_t           win_src;
    src_idx_t           cur_src;
    logic               still_ok;
    logic [VEC_W-1:0]   win_vec;

    irq_tt_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rank_reg  (rank_reg),
        .lvl_en    (lvl_en),
        .clr_sw    (clr_sw)
    );

    irq_tt_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_req),
        .clr_sw  (clr_sw),
        .clr_ack (clr_ack),
        .pend    (pend)
    );

    irq_tt_arb u_arb (
        .pend     (pend),
        .lvl_en   (lvl_en),
        .rank_reg (rank_reg),
        .any_req  (any_req),
        .win_src  (win_src)
    );

    // Acknowledge clear strobe, only for sources configured as auto-clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack_clr
        if (AUTO_CLR[i]) begin : g_auto
            assign clr_ack[i] = ack && irq && (cur_src == SRC_W'(i));
        end else begin : g_manual
            assign clr_ack[i] = 1'b0;
        end
    end

    // Presented source stays valid while pending, its level on, and enabled.
    assign still_ok = pend[cur_src] && lvl_en[src_level(int'(cur_src))] && glb_en;
    assign win_vec  = VEC_BASE + VEC_W'({win_src, 1'b0});

    // Request/vector output register with hold while the request is up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            cur_src <= '0;
            vec     <= '0;
        end else if (irq) begin
            if (ack || !still_ok) irq <= 1'b0;
        end else if (glb_en && any_req) begin
            irq     <= 1'b1;
            cur_src <= win_src;
            vec     <= win_vec;
        end
    end
endmodule

// File: rtl/irq_two_tier_chk.sv
// Checker for the two-tier interrupt controller; observes ports only.
module irq_two_tier_chk #(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
    parameter int               NSRC     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             ack,
    input logic             irq,
    input logic [VEC_W-1:0] vec
);
    localparam logic [VEC_W-1:0] VEC_TOP = VEC_BASE + VEC_W'(2 * (NSRC - 1));

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!irq && vec == '0)); // R1
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec >= VEC_BASE && vec <= VEC_TOP && vec[0] == VEC_BASE[0])); // R3
    AST_GLB_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !glb_en |=> !irq); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (irq && ack) |=> !irq); // R8
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (!irq || $stable(vec))); // R11
endmodule

bind irq_two_tier_ctrl irq_two_tier_chk #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .NSRC     (irq_tt_pkg::NUM_SRC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .glb_en (glb_en),
    .ack    (ack),
    .irq    (irq),
    .vec    (vec)
);

// File: tb/tb_irq_two_tier_ctrl.sv
`timescale 1ns/1ps
module tb_irq_two_tier_ctrl;
    localparam logic [7:0] VB = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] src_req = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       glb_en = 1'b0;
    logic       ack = 1'b0;
    logic       irq;
    logic [7:0] vec;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic       e_irq;
        logic [7:0] e_vec;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    irq_two_tier_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .glb_en(glb_en),
        .ack(ack), .irq(irq), .vec(vec)
    );

    // Monitor: compare queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (irq !== e.e_irq || (e.e_irq && vec !== e.e_vec)) begin
                    bad++;
                    $display("FAIL %s: irq=%0b vec=%02h expected irq=%0b vec=%02h",
                             e.tag, irq, vec, e.e_irq, e.e_vec);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input logic ei, input int src, input string tag);
        exp_t e;
        e.e_irq = ei;
        e.e_vec = VB + 8'(2 * src);
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [8:0] m);
        src_req = m;
        cyc();
        src_req = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc();
        ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarizes.
    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: stimulus and expected results per requirement.
    initial begin
        #2;
        cyc(); cyc();
        expect_out(0, 0, "R1 reset quiet");
        rst_n = 1'b1;
        cyc();
        expect_out(0, 0, "R1 after reset");

        // R2: latch while level disabled and global enable off
        pulse(9'h004);
        cyc();
        expect_out(0, 0, "R2 masked latch");
        wr(2'd1, 8'hFF);
        cyc();
        expect_out(0, 0, "R7 global off");
        glb_en = 1'b1;
        cyc();
        expect_out(1, 2, "R2 R3 late enable");
        glb_en = 1'b0;
        cyc();
        expect_out(0, 0, "R7 drop on global off");
        glb_en = 1'b1;
        cyc();
        expect_out(1, 2, "R7 re-enable");
        do_ack();
        expect_out(0, 0, "R8 ack gap");
        cyc();
        expect_out(0, 0, "R8 auto cleared");

        // R9 / R10: software-clear source 7
        pulse(9'h080);
        cyc();
        expect_out(1, 7, "R3 src7 vector");
        do_ack();
        expect_out(0, 0, "R9 ack gap");
        cyc();
        expect_out(1, 7, "R9 re-presented");
        wr(2'd2, 8'h7F);
        cyc();
        expect_out(1, 7, "R10 zero bit no effect");
        wr(2'd2, 8'h80);
        expect_out(1, 7, "R10 drop is one edge late");
        cyc();
        expect_out(0, 0, "R10 cleared");

        // R6: fixed order inside levels
        pulse(9'h018);
        cyc();
        expect_out(1, 3, "R6 src3 before src4");
        wr(2'd2, 8'h08);
        cyc();
        expect_out(0, 0, "R10 src3 cleared");
        cyc();
        expect_out(1, 4, "R6 src4 next");
        wr(2'd2, 8'h10);
        cyc();
        expect_out(0, 0, "R10 src4 cleared");
        pulse(9'h003);
        cyc();
        expect_out(1, 0, "R6 src0 before src1");
        do_ack();
        expect_out(0, 0, "R8 src0 ack");
        cyc();
        expect_out(1, 1, "R6 src1 next");
        wr(2'd2, 8'h02);
        cyc();
        expect_out(0, 0, "R10 src1 cleared");

        // R4: ranks invert the level-number order
        wr(2'd0, 8'h13);
        pulse(9'h124);
        cyc();
        expect_out(1, 8, "R4 level7 rank0 first");
        do_ack();
        cyc();
        expect_out(1, 5, "R4 level3 rank2 second");
        do_ack();
        cyc();
        expect_out(1, 2, "R4 level1 rank3 last");
        do_ack();
        cyc();
        expect_out(0, 0, "R8 all auto cleared");

        // R5: equal rank across groups, lower level wins
        wr(2'd0, 8'hC9);
        pulse(9'h124);
        cyc();
        expect_out(1, 2, "R5 tie level1 over level3");
        do_ack();
        cyc();
        expect_out(1, 5, "R4 level3 over level7");
        do_ack();
        cyc();
        expect_out(1, 8, "R4 level7 last");
        do_ack();
        cyc();
        expect_out(0, 0, "R8 drained");

        // R11: vector holds while a higher request arrives
        wr(2'd0, 8'h00);
        pulse(9'h040);
        cyc();
        expect_out(1, 6, "R11 src6 presented");
        pulse(9'h001);
        cyc();
        expect_out(1, 6, "R11 vector held");
        do_ack();
        expect_out(0, 0, "R8 src6 ack");
        cyc();
        expect_out(1, 0, "R11 src0 after ack");
        do_ack();
        cyc();
        expect_out(0, 0, "R8 src0 cleared");

        // R5: tie inside one rank group
        pulse(9'h180);
        cyc();
        expect_out(1, 7, "R5 level6 over level7");
        wr(2'd2, 8'h80);
        cyc();
        expect_out(0, 0, "R10 src7 cleared");
        cyc();
        expect_out(1, 8, "R5 level7 next");
        do_ack();
        cyc();
        expect_out(0, 0, "R8 src8 cleared");

        // R12: level enable and high clear address
        wr(2'd1, 8'h7F);
        pulse(9'h100);
        cyc();
        expect_out(0, 0, "R12 level7 disabled");
        wr(2'd3, 8'h01);
        wr(2'd1, 8'hFF);
        cyc();
        expect_out(0, 0, "R12 src8 cleared via addr3");

        cyc(); cyc();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule